// File: doc/BRIEF.md
# NAND Flash Host Bus Sequencer

This block sits on the host side of an 8-bit multiplexed NAND flash bus. A local agent hands it one request at a time: a command byte, an address byte, a data byte to write, a data byte to read, a wait for the flash to become ready, or a request to release chip enable. The block converts each request into pin activity on chip enable, the command and address latch strobes, the write and read strobes, the write-protect line and the shared data port. All pulse widths and margins come from clock-count parameters.

Bytes written to the flash are driven onto the shared port only while a write strobe cycle is in progress. Reads strobe the read line low, release the port, and capture the flash's byte when the access count runs out, just as the read strobe returns high. The flash moves to the next column on every read strobe, so back-to-back read requests stream consecutive bytes. The open-drain ready/busy line is passed through a two-stage synchronizer. A wait request first lets a fixed number of clocks pass, then completes on the first synchronized high level. Chip enable falls with the first bus request and stays low until the agent asks for it to be released, so it is never raised while the flash is busy with a read transfer.

Top module: `nand_bus_seq`

## Requirements
- R1: During and after reset, chip enable, write strobe and read strobe are high, both latch strobes are low, write-protect is low, the port is released (output enable 0), no done pulse is given and a request is accepted.
- R2: Opcode 0 (command) raises the command latch strobe with the address latch strobe low and drives the byte with output enable high for SETUP_CYC clocks. The write strobe is then low for WE_LOW_CYC clocks. The strobe, byte and output enable are held for HOLD_CYC clocks after the write strobe rises. The flash takes the byte at that rising edge.
- R3: Opcode 1 (address) runs the same write cycle with the address latch strobe high and the command latch strobe low.
- R4: Opcode 2 (write data) runs the same write cycle with both latch strobes low.
- R5: Opcode 3 (read) keeps the port released and drives the read strobe low for ACCESS_CYC clocks. It returns the port value present on the clock edge where the strobe rises, then keeps the strobe high for RE_HIGH_CYC clocks. Successive reads return consecutive flash columns.
- R6: Each request ends with a one-cycle done pulse. Counting the accept edge as edge 1, the pulse appears after edge SETUP_CYC+WE_LOW_CYC+HOLD_CYC+1 for opcodes 0-2, after edge ACCESS_CYC+RE_HIGH_CYC+1 for opcode 3, and after edge 1 for opcodes 5-7.
- R7: Opcode 4 (wait) waits BUSY_WAIT_CYC clocks and then completes on the first synchronized high of ready/busy. With the line already high, done follows edge BUSY_WAIT_CYC+2. When the line rises later, done follows the third clock edge after the rise.
- R8: Chip enable falls with any opcode 0-3 and stays low, including through every wait, until opcode 5 raises it.
- R9: Write-protect is a registered copy of the local write-allow input.
- R10: Opcodes 6 and 7 produce a done pulse and no strobe. They leave chip enable and the port unchanged.
- R11: A request is accepted only when the block is idle. The request-ready output is low from acceptance until the done pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted this cycle if valid |
| req_op | input | 3 | Opcode: 0 cmd, 1 addr, 2 wdata, 3 read, 4 wait, 5 release CE |
| req_byte | input | 8 | Byte for opcodes 0-2 |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_byte | output | 8 | Byte captured by the last read |
| wr_allow | input | 1 | Local write-allow bit for the write-protect line |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch strobe |
| nand_ale | output | 1 | Address latch strobe |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_wp_n | output | 1 | Write protect, active low |
| nand_io_out | output | 8 | Byte driven onto the shared port |
| nand_io_oe | output | 1 | Port output enable |
| nand_io_in | input | 8 | Byte read from the shared port |
| nand_rb | input | 1 | Ready/busy from the open-drain line, high when ready |

## Verification
Every byte value from 0 to 255 is sent as a command, as an address and as write data. This separates the three latch-strobe combinations and exposes any stuck or swapped port bit. Each write cycle has its setup, low and hold phases measured. A full 256-column read stream after address zero, plus a second stream starting mid-page, separates correct column advance and capture timing from off-by-one strobe counts. Waits are run with ready already high and with a delayed release, which pins the synchronizer depth. Chip release and the reserved opcodes are run between bus operations to show that they leave the strobes idle.

// File: rtl/nand_bus_seq.sv
module nand_bus_seq #(
  parameter int SETUP_CYC     = 2,
  parameter int WE_LOW_CYC    = 3,
  parameter int HOLD_CYC      = 2,
  parameter int ACCESS_CYC    = 3,
  parameter int RE_HIGH_CYC   = 2,
  parameter int BUSY_WAIT_CYC = 4,
  parameter int CW            = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic [2:0] req_op,
  input  logic [7:0] req_byte,
  output logic       rsp_done,
  output logic [7:0] rsp_byte,
  input  logic       wr_allow,
  output logic       nand_ce_n,
  output logic       nand_cle,
  output logic       nand_ale,
  output logic       nand_we_n,
  output logic       nand_re_n,
  output logic       nand_wp_n,
  output logic [7:0] nand_io_out,
  output logic       nand_io_oe,
  input  logic [7:0] nand_io_in,
  input  logic       nand_rb
);
  localparam logic [2:0] OP_CMD = 3'd0, OP_ADDR = 3'd1, OP_WDATA = 3'd2,
                         OP_READ = 3'd3, OP_WAIT = 3'd4, OP_DESEL = 3'd5;

  typedef enum logic [2:0] {
    S_IDLE, S_SETUP, S_WLO, S_HOLD, S_RLO, S_RHI, S_WDLY, S_POLL
  } state_t;

  state_t          st;
  logic [CW-1:0]   cnt;
  logic [1:0]      rb_sync;

  wire cnt_end = (cnt == '0);
  wire rb_hi   = rb_sync[1];

  assign req_ready = (st == S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rb_sync   <= 2'b00;
      nand_wp_n <= 1'b0;
    end else begin
      rb_sync   <= {rb_sync[0], nand_rb};
      nand_wp_n <= wr_allow;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      cnt         <= '0;
      nand_ce_n   <= 1'b1;
      nand_cle    <= 1'b0;
      nand_ale    <= 1'b0;
      nand_we_n   <= 1'b1;
      nand_re_n   <= 1'b1;
      nand_io_out <= 8'h00;
      nand_io_oe  <= 1'b0;
      rsp_done    <= 1'b0;
      rsp_byte    <= 8'h00;
    end else begin
      rsp_done <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          case (req_op)
            OP_CMD, OP_ADDR, OP_WDATA: begin
              nand_ce_n   <= 1'b0;
              nand_cle    <= (req_op == OP_CMD);
              nand_ale    <= (req_op == OP_ADDR);
              nand_io_out <= req_byte;
              nand_io_oe  <= 1'b1;
              cnt         <= CW'(SETUP_CYC - 1);
              st          <= S_SETUP;
            end
            OP_READ: begin
              nand_ce_n <= 1'b0;
              nand_re_n <= 1'b0;
              cnt       <= CW'(ACCESS_CYC - 1);
              st        <= S_RLO;
            end
            OP_WAIT: begin
              cnt <= CW'(BUSY_WAIT_CYC - 1);
              st  <= S_WDLY;
            end
            OP_DESEL: begin
              nand_ce_n <= 1'b1;
              rsp_done  <= 1'b1;
            end
            default: rsp_done <= 1'b1;
          endcase
        end
        S_SETUP: if (cnt_end) begin
          nand_we_n <= 1'b0;
          cnt       <= CW'(WE_LOW_CYC - 1);
          st        <= S_WLO;
        end else cnt <= cnt - 1'b1;
        S_WLO: if (cnt_end) begin
          nand_we_n <= 1'b1;
          cnt       <= CW'(HOLD_CYC - 1);
          st        <= S_HOLD;
        end else cnt <= cnt - 1'b1;
        S_HOLD: if (cnt_end) begin
          nand_cle   <= 1'b0;
          nand_ale   <= 1'b0;
          nand_io_oe <= 1'b0;
          rsp_done   <= 1'b1;
          st         <= S_IDLE;
        end else cnt <= cnt - 1'b1;
        S_RLO: if (cnt_end) begin
          nand_re_n <= 1'b1;
          rsp_byte  <= nand_io_in;
          cnt       <= CW'(RE_HIGH_CYC - 1);
          st        <= S_RHI;
        end else cnt <= cnt - 1'b1;
        S_RHI: if (cnt_end) begin
          rsp_done <= 1'b1;
          st       <= S_IDLE;
        end else cnt <= cnt - 1'b1;
        S_WDLY: if (cnt_end) st <= S_POLL;
        else cnt <= cnt - 1'b1;
        S_POLL: if (rb_hi) begin
          rsp_done <= 1'b1;
          st       <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R5
  port_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_io_oe && !nand_re_n));

  // R2
  latch_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_cle && nand_ale));

  // R2
  we_low_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!nand_we_n && $past(!nand_we_n)) |->
      ($stable(nand_io_out) && $stable(nand_cle) && $stable(nand_ale) && nand_io_oe));

  // R2
  we_rise_driven_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nand_we_n) |-> (nand_io_oe && !nand_ce_n));

  // R8
  ce_held_in_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WDLY || st == S_POLL) |-> $stable(nand_ce_n));

  // R7
  ready_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && $past(st == S_POLL)) |-> $past(nand_rb, 3));

  // R9
  wp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nand_wp_n |-> $past(wr_allow));
endmodule

// File: tb/test_nand_bus_seq.sv
`timescale 1ns/100ps
module test_nand_bus_seq;
  localparam int SU = 2, WL = 3, HD = 2, AC = 3, RH = 2, BW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [2:0] req_op = 3'd0;
  logic [7:0] req_byte = 8'h00;
  logic rsp_done;
  logic [7:0] rsp_byte;
  logic wr_allow = 1'b0;
  logic nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_wp_n, nand_io_oe;
  logic [7:0] nand_io_out;
  logic [7:0] nand_io_in = 8'h00;
  logic nand_rb = 1'b1;

  nand_bus_seq #(.SETUP_CYC(SU), .WE_LOW_CYC(WL), .HOLD_CYC(HD), .ACCESS_CYC(AC),
                 .RE_HIGH_CYC(RH), .BUSY_WAIT_CYC(BW), .CW(8)) i_nand_bus_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_byte(req_byte), .rsp_done(rsp_done), .rsp_byte(rsp_byte),
    .wr_allow(wr_allow), .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
    .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_wp_n(nand_wp_n),
    .nand_io_out(nand_io_out), .nand_io_oe(nand_io_oe), .nand_io_in(nand_io_in),
    .nand_rb(nand_rb));

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  bit model_on = 1'b0, finished = 1'b0;
  always @(posedge clk) cyc <= cyc + 1;

  // flash model
  logic [7:0] col = 8'h00, last_byte = 8'h00;
  logic last_cle = 1'b0, last_ale = 1'b0, last_oe = 1'b0;
  always @(posedge nand_we_n) if (model_on) begin
    last_cle = nand_cle; last_ale = nand_ale; last_oe = nand_io_oe; last_byte = nand_io_out;
    if (nand_ale) col = nand_io_out;
  end
  always @(negedge nand_re_n) if (model_on) begin
    #1 nand_io_in = col * 8'd7 + 8'd3;
    col = col + 8'd1;
  end
  always @(posedge nand_re_n) if (model_on) begin
    #1 nand_io_in = 8'hEE;
  end

  int lat, su_n, wl_n, hd_n, rl_n, oebad, strobes, cehigh, rdyhi, done_cyc;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op, input logic [7:0] b);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_op = op; req_byte = b;
    @(posedge clk); #1 req_valid = 1'b0;
    lat = 0; su_n = 0; wl_n = 0; hd_n = 0; rl_n = 0; oebad = 0;
    strobes = 0; cehigh = 0; rdyhi = 0;
    forever begin
      @(negedge clk);
      lat++;
      if (!nand_we_n) wl_n++;
      else if (nand_io_oe && wl_n == 0) su_n++;
      else if (nand_io_oe) hd_n++;
      if (!nand_re_n) rl_n++;
      if (nand_io_oe && !nand_re_n) oebad++;
      if (!nand_we_n || !nand_re_n) strobes++;
      if (nand_ce_n) cehigh++;
      if (rsp_done) begin done_cyc = cyc; break; end
      if (req_ready) rdyhi++;
    end
  endtask

  task automatic check_write(input logic [2:0] op, input logic [7:0] b, input string req);
    issue(op, b);
    chk(last_byte == b && last_oe, req, int'(last_byte), int'(b));
    chk(last_cle == (op == 3'd0) && last_ale == (op == 3'd1), req,
        int'({last_cle, last_ale}), int'({op == 3'd0, op == 3'd1}));
    chk(su_n == SU && wl_n == WL && hd_n == HD, req, su_n*100 + wl_n*10 + hd_n, SU*100 + WL*10 + HD);
    // R6
    chk(lat == SU + WL + HD + 1, "R6", lat, SU + WL + HD + 1);
  endtask

  initial begin
    fork
      begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
          fails++; checks++;
          $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
          $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
          $finish;
        end
      end
    join_none

    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 during reset
    chk(nand_ce_n && nand_we_n && nand_re_n && !nand_cle && !nand_ale && !nand_wp_n && !nand_io_oe,
        "R1", int'({nand_ce_n, nand_we_n, nand_re_n, nand_cle, nand_ale, nand_wp_n, nand_io_oe}), 7'b1110000);
    rst_n = 1'b1; model_on = 1'b1;
    @(negedge clk);
    chk(req_ready && !rsp_done && nand_ce_n && !nand_io_oe, "R1",
        int'({req_ready, rsp_done, nand_ce_n, nand_io_oe}), 4'b1010);

    // R9 write protect
    wr_allow = 1'b1; @(negedge clk);
    chk(nand_wp_n == 1'b1, "R9", int'(nand_wp_n), 1);
    wr_allow = 1'b0; @(negedge clk);
    chk(nand_wp_n == 1'b0, "R9", int'(nand_wp_n), 0);
    wr_allow = 1'b1; @(negedge clk);

    // R2, R3, R4 byte sweeps
    for (int i = 0; i < 256; i++) check_write(3'd0, 8'(i), "R2");
    // R8 chip enable low after bus activity
    chk(!nand_ce_n, "R8", int'(nand_ce_n), 0);
    // R11 ready low while busy
    chk(rdyhi == 0, "R11", rdyhi, 0);
    for (int i = 0; i < 256; i++) check_write(3'd1, 8'(255 - i), "R3");
    for (int i = 0; i < 256; i++) check_write(3'd2, 8'(i ^ 8'h5A), "R4");

    // R5 read stream from column 0
    check_write(3'd1, 8'h00, "R3");
    for (int i = 0; i < 256; i++) begin
      issue(3'd3, 8'h00);
      chk(rsp_byte == 8'(i * 7 + 3), "R5", int'(rsp_byte), (i * 7 + 3) & 255);
      chk(rl_n == AC && oebad == 0, "R5", rl_n, AC);
      chk(lat == AC + RH + 1, "R6", lat, AC + RH + 1);
    end
    // R5 stream from mid page
    check_write(3'd1, 8'h80, "R3");
    for (int i = 0; i < 4; i++) begin
      issue(3'd3, 8'h00);
      chk(rsp_byte == 8'((128 + i) * 7 + 3), "R5", int'(rsp_byte), ((128 + i) * 7 + 3) & 255);
    end

    // R7 wait with line already high
    nand_rb = 1'b1;
    issue(3'd4, 8'h00);
    chk(lat == BW + 2, "R7", lat, BW + 2);
    chk(cehigh == 0, "R8", cehigh, 0);

    // R7 wait with delayed release
    begin
      int rel_cyc;
      @(negedge clk); nand_rb = 1'b0;
      repeat (3) @(negedge clk);
      rel_cyc = 0;
      fork
        issue(3'd4, 8'h00);
        begin
          repeat (12) @(negedge clk);
          nand_rb = 1'b1; rel_cyc = cyc;
        end
      join
      chk(done_cyc - rel_cyc == 3, "R7", done_cyc - rel_cyc, 3);
      chk(cehigh == 0, "R8", cehigh, 0);
      chk(rdyhi == 0, "R11", rdyhi, 0);
    end

    // R8 release chip enable
    issue(3'd5, 8'h00);
    chk(nand_ce_n && lat == 1 && strobes == 0, "R8", lat, 1);
    issue(3'd3, 8'h00);
    chk(!nand_ce_n, "R8", int'(nand_ce_n), 0);

    // R10 reserved opcodes, CE low
    issue(3'd6, 8'hA5);
    chk(lat == 1 && strobes == 0 && !nand_ce_n && !nand_io_oe, "R10", lat*10 + strobes, 10);
    issue(3'd7, 8'h3C);
    chk(lat == 1 && strobes == 0 && !nand_ce_n && !nand_io_oe, "R10", lat*10 + strobes, 10);
    // R10 reserved opcode, CE high
    issue(3'd5, 8'h00);
    issue(3'd7, 8'h00);
    chk(lat == 1 && strobes == 0 && nand_ce_n, "R10", int'(nand_ce_n), 1);
    @(negedge clk);
    chk(!rsp_done && req_ready, "R6", int'(rsp_done), 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule